// File: doc/BRIEF.md
# Receive FIFO Packet Release Controller

This block answers each host IN-token request for the receive FIFO. The answer is either a NAK or a grant that carries a byte count. The surrounding logic then drains exactly that count from the FIFO.

By default data is held back until a full 64-byte packet is available. Two conditions release a smaller amount early:
- the serial line has gone quiet for more than three character times;
- a low-latency enable is set.

An idle timer counts character times since the most recent received character. One character time is the configured frame length in bits multiplied by the period of the baud bit-time tick.

A separate comparator flags baud-rate settings under 40960 bps. Configuration logic can use that flag to turn on low latency.

Top module: `rx_release_ctrl`

## Requirements
- R1: `resp_valid` is high for exactly the one cycle after a cycle with `req` high, and low at every other time. After reset, `resp_valid`, `resp_grant` and `resp_count` are all 0.
- R2: A request made while `fill_count` ≥ 64 is answered with `resp_grant`=1 and `resp_count`=64, whatever the idle and low-latency state.
- R3: A request made while `fill_count`=0 is answered with a NAK (`resp_grant`=0, `resp_count`=0), even when idle or low latency applies.
- R4: A request made while `fill_count` is between 1 and 63, with `low_lat_en`=0 and the idle condition not reached, is answered with a NAK.
- R5: The idle condition is reached on the bit tick that completes the fourth character time after the timer was restarted. With `frame_bits`=N, that is the 4·N-th tick. After 4·N−1 ticks the condition is not reached.
- R6: A request made while the idle condition holds and `fill_count` is between 1 and 63 is granted with `resp_count` equal to `fill_count`.
- R7: A `char_rcvd` pulse clears the idle condition and restarts the character-time count from zero.
- R8: A grant that takes the whole FIFO content (`fill_count` ≤ 64 at the request) clears the idle condition and restarts the timer.
- R9: A request made while `low_lat_en`=1 and `fill_count` is between 1 and 63 is granted at once with `resp_count` equal to `fill_count`.
- R10: `slow_baud` is 1 exactly when `baud_cfg` is below 40960. It is combinational.
- R11: `resp_count` is the value decided in the request cycle. Changes to `fill_count` after that cycle do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_count | input | 8 | Bytes currently held in the receive FIFO |
| char_rcvd | input | 1 | One-cycle strobe per received character |
| bit_tick | input | 1 | One-cycle strobe per serial bit time |
| frame_bits | input | 4 | Frame length in bits (start, data, parity, stop) |
| low_lat_en | input | 1 | Release any nonzero content immediately |
| req | input | 1 | Host IN request pulse |
| baud_cfg | input | 24 | Configured baud rate in bps |
| slow_baud | output | 1 | Baud rate is below 40960 |
| resp_valid | output | 1 | Response strobe, one cycle after `req` |
| resp_grant | output | 1 | 1 = grant, 0 = NAK |
| resp_count | output | 7 | Bytes granted (0 on NAK) |

## Verification
The bench targets the idle-timeout boundary. It applies 4·N−1 ticks and then 4·N ticks, at two frame lengths. A timer that is off by one character or one bit, or that ignores `frame_bits`, would grant too early or too late.

The bench also checks that the idle condition is cleared both by a new character and by a grant that empties the FIFO. A design that kept the condition sticky would grant stale partial packets back to back.

Empty-FIFO requests are issued with idle and low latency both active. A design that granted a zero-byte packet there would be caught.

The bench also covers:
- count capping above 64;
- the 40959/40960 comparator edge;
- a fill level that changes after the request, which exposes a count taken from the live input instead of the latched one.

// File: rtl/rxrel_pkg.sv
package rxrel_pkg;
    localparam int unsigned PKT_MAX_DEF    = 64;
    localparam int unsigned IDLE_CHARS_DEF = 4;
    localparam int unsigned SLOW_BAUD_DEF  = 40960;

    typedef enum logic {
        ANS_NAK   = 1'b0,
        ANS_GRANT = 1'b1
    } answer_e;
endpackage

// File: rtl/rxrel_idle_timer.sv
module rxrel_idle_timer #(
    parameter int unsigned FRM_W      = 4,
    parameter int unsigned IDLE_CHARS = rxrel_pkg::IDLE_CHARS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_rcvd,
    input  logic             bit_tick,
    input  logic [FRM_W-1:0] frame_bits,
    input  logic             flush,
    output logic             idle
);
    localparam int unsigned CHR_W = $clog2(IDLE_CHARS + 1);
    localparam logic [CHR_W-1:0] LAST_CHR = CHR_W'(IDLE_CHARS - 1);

    typedef struct packed {
        logic [FRM_W-1:0] bit_cnt;
        logic [CHR_W-1:0] chr_cnt;
        logic             idle;
    } tmr_t;

    tmr_t t_d, t_q;
    logic frame_done;

    always_comb begin
        t_d        = t_q;
        frame_done = ({1'b0, t_q.bit_cnt} + 1'b1) >= {1'b0, frame_bits};
        if (char_rcvd || flush) begin
            t_d = '0;
        end else if (bit_tick && !t_q.idle) begin
            if (frame_done) begin
                t_d.bit_cnt = '0;
                if (t_q.chr_cnt == LAST_CHR) t_d.idle = 1'b1;
                else                         t_d.chr_cnt = t_q.chr_cnt + 1'b1;
            end else begin
                t_d.bit_cnt = t_q.bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign idle = t_q.idle;

    assert_char_clears_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        char_rcvd |=> !idle);
    assert_flush_clears_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !idle);
    assert_idle_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> ($past(bit_tick) && !$past(char_rcvd)));
endmodule

// File: rtl/rxrel_decide.sv
module rxrel_decide #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned OUT_W   = 7,
    parameter int unsigned PKT_MAX = rxrel_pkg::PKT_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] fill_count,
    input  logic             idle,
    input  logic             low_lat_en,
    output logic             flush,
    output logic             resp_valid,
    output logic             resp_grant,
    output logic [OUT_W-1:0] resp_count
);
    import rxrel_pkg::*;

    localparam logic [CNT_W-1:0] PKT_FULL = CNT_W'(PKT_MAX);

    typedef struct packed {
        logic             valid;
        answer_e          ans;
        logic [OUT_W-1:0] count;
    } resp_t;

    resp_t r_d, r_q;
    logic  full_pkt, empty, early_ok;

    always_comb begin
        full_pkt = fill_count >= PKT_FULL;
        empty    = fill_count == '0;
        early_ok = !empty && (low_lat_en || idle);
        r_d      = '0;
        if (req) begin
            r_d.valid = 1'b1;
            if (full_pkt) begin
                r_d.ans   = ANS_GRANT;
                r_d.count = OUT_W'(PKT_MAX);
            end else if (early_ok) begin
                r_d.ans   = ANS_GRANT;
                r_d.count = fill_count[OUT_W-1:0];
            end
        end
        flush = req && (r_d.ans == ANS_GRANT) && (fill_count <= PKT_FULL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign resp_valid = r_q.valid;
    assign resp_grant = (r_q.ans == ANS_GRANT);
    assign resp_count = r_q.count;

    assert_resp_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> resp_valid);
    assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !resp_valid);
    assert_full_packet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && fill_count >= PKT_FULL) |=> (resp_grant && resp_count == OUT_W'(PKT_MAX)));
    assert_empty_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && fill_count == '0) |=> (!resp_grant && resp_count == '0));
    assert_low_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && low_lat_en && fill_count != '0) |=> resp_grant);
    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ({1'b0, resp_count} <= {1'b0, $past(fill_count)}));
endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
    parameter int unsigned FIFO_DEPTH = 128,
    parameter int unsigned PKT_MAX    = rxrel_pkg::PKT_MAX_DEF,
    parameter int unsigned FRM_W      = 4,
    parameter int unsigned BAUD_W     = 24,
    parameter int unsigned IDLE_CHARS = rxrel_pkg::IDLE_CHARS_DEF,
    parameter int unsigned SLOW_BAUD  = rxrel_pkg::SLOW_BAUD_DEF,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned OUT_W     = $clog2(PKT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fill_count,
    input  logic              char_rcvd,
    input  logic              bit_tick,
    input  logic [FRM_W-1:0]  frame_bits,
    input  logic              low_lat_en,
    input  logic              req,
    input  logic [BAUD_W-1:0] baud_cfg,
    output logic              slow_baud,
    output logic              resp_valid,
    output logic              resp_grant,
    output logic [OUT_W-1:0]  resp_count
);
    logic idle;
    logic flush;

    assign slow_baud = baud_cfg < BAUD_W'(SLOW_BAUD);

    rxrel_idle_timer #(
        .FRM_W      (FRM_W),
        .IDLE_CHARS (IDLE_CHARS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_rcvd  (char_rcvd),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .flush      (flush),
        .idle       (idle)
    );

    rxrel_decide #(
        .CNT_W   (CNT_W),
        .OUT_W   (OUT_W),
        .PKT_MAX (PKT_MAX)
    ) u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .fill_count (fill_count),
        .idle       (idle),
        .low_lat_en (low_lat_en),
        .flush      (flush),
        .resp_valid (resp_valid),
        .resp_grant (resp_grant),
        .resp_count (resp_count)
    );
endmodule

// File: tb/sim_rx_release_ctrl.sv
module sim_rx_release_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  fill_count;
    logic        char_rcvd, bit_tick, low_lat_en, req;
    logic [3:0]  frame_bits;
    logic [23:0] baud_cfg;
    logic        slow_baud, resp_valid, resp_grant;
    logic [6:0]  resp_count;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_release_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fill_count(fill_count), .char_rcvd(char_rcvd),
        .bit_tick(bit_tick), .frame_bits(frame_bits), .low_lat_en(low_lat_en),
        .req(req), .baud_cfg(baud_cfg), .slow_baud(slow_baud),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_count(resp_count)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ask(input string tag, input int exp_grant, input int exp_cnt);
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        check({tag, " valid"}, int'(resp_valid), 1);
        check({tag, " grant"}, int'(resp_grant), exp_grant);
        check({tag, " count"}, int'(resp_count), exp_cnt);
        @(negedge clk);
        check({tag, " valid drops (R1)"}, int'(resp_valid), 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bit_tick = 1'b1;
        end
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic new_char();
        @(negedge clk) char_rcvd = 1'b1;
        @(negedge clk) char_rcvd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset valid", int'(resp_valid), 0);
        check("R1 reset grant", int'(resp_grant), 0);
        check("R1 reset count", int'(resp_count), 0);
    endtask

    task automatic t_full_packet();
        new_char();
        fill_count = 8'd64;  ask("R2 fill64", 1, 64);
        fill_count = 8'd128; ask("R2 fill128", 1, 64);
    endtask

    task automatic t_partial_nak();
        new_char();
        fill_count = 8'd63; ask("R4 fill63", 0, 0);
        fill_count = 8'd1;  ask("R4 fill1", 0, 0);
    endtask

    task automatic t_idle_boundary(input int nbits, input int fill);
        frame_bits = 4'(nbits);
        fill_count = 8'(fill);
        new_char();
        ticks(4 * nbits - 1);
        ask("R5 one tick short", 0, 0);
        ticks(1);
        ask("R6 idle grant", 1, fill);
        ask("R8 idle cleared by drain", 0, 0);
        ticks(4 * nbits - 1);
        ask("R8 timer restarted short", 0, 0);
        ticks(1);
        ask("R8 timer restarted full", 1, fill);
    endtask

    task automatic t_char_restart();
        frame_bits = 4'd10;
        fill_count = 8'd9;
        new_char();
        ticks(39);
        new_char();
        ticks(39);
        ask("R7 char restarts timer", 0, 0);
        ticks(1);
        ask("R7 idle after restart", 1, 9);
    endtask

    task automatic t_empty();
        fill_count = 8'd0;
        frame_bits = 4'd10;
        new_char();
        ticks(40);
        ask("R3 empty while idle", 0, 0);
        low_lat_en = 1'b1;
        ask("R3 empty with low latency", 0, 0);
        low_lat_en = 1'b0;
    endtask

    task automatic t_low_latency();
        new_char();
        low_lat_en = 1'b1;
        fill_count = 8'd7;  ask("R9 low latency fill7", 1, 7);
        fill_count = 8'd90; ask("R2 low latency fill90", 1, 64);
        low_lat_en = 1'b0;
    endtask

    task automatic t_latch();
        new_char();
        low_lat_en = 1'b1;
        fill_count = 8'd10;
        @(negedge clk) req = 1'b1;
        @(negedge clk) begin
            req = 1'b0;
            fill_count = 8'd30;
        end
        #1;
        check("R11 count latched", int'(resp_count), 10);
        low_lat_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_slow_baud();
        baud_cfg = 24'd40959; #1 check("R10 40959 slow", int'(slow_baud), 1);
        baud_cfg = 24'd40960; #1 check("R10 40960 not slow", int'(slow_baud), 0);
        baud_cfg = 24'd9600;  #1 check("R10 9600 slow", int'(slow_baud), 1);
        baud_cfg = 24'd115200; #1 check("R10 115200 not slow", int'(slow_baud), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fill_count = '0; char_rcvd = 1'b0; bit_tick = 1'b0;
        low_lat_en = 1'b0; req = 1'b0; frame_bits = 4'd10; baud_cfg = 24'd115200;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_packet();
        t_partial_nak();
        t_idle_boundary(10, 5);
        t_idle_boundary(7, 63);
        t_char_restart();
        t_empty();
        t_low_latency();
        t_latch();
        t_slow_baud();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule